// File: doc/BRIEF.md
# DMA request channel multiplexer

This block sits between the DMA request lines of many peripherals and a smaller set of DMA engine channels. Software programs one configuration byte per channel. The byte picks which of 64 request slots reaches that channel. It can switch the channel off, or pass the chosen slot straight through. It can also make the chosen slot wait for a pulse from a periodic timer before it is forwarded.

The configuration bytes are reached through a small memory-mapped port. The port takes byte, halfword and word accesses. Four channel bytes share one 32-bit word, and the byte lanes are big-endian. An access whose address does not fit its width is refused with a one-cycle error response. Slot 0 stands for "nothing routed".

Top module: `dma_req_router`

## Requirements
- R1: Configuration byte layout: bit 7 (numbered bit 0 in MSB-first order) is the channel enable, bit 6 is the trigger-mode enable, and bits 5:0 hold the source slot number that indexes `src_req`.
- R2: After reset every configuration byte is zero, every `ch_req` bit is low whatever `src_req` and `trig_pulse` do, and reads return zero.
- R3: With the enable bit at 0, the channel's `ch_req` bit stays low regardless of the trigger bit, the source field and the inputs.
- R4: With enable 1 and trigger 0, `ch_req[n]` follows `src_req[slot]` combinationally.
- R5: With enable 1 and trigger 1, a `trig_pulse[n]` sampled at a clock edge arms the channel, even while the source is low. While armed, `ch_req[n]` equals `src_req[slot]`; while unarmed it is low. The armed state clears at the edge where the selected source is sampled low after having been sampled high.
- R6: Source slot 0 always yields an inactive channel request.
- R7: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. An aligned access gets `rsp_valid` one cycle later. Channel n lives at byte offset n, in lane bits [31-8*(n%4) -: 8] of `req_wdata`/`rsp_rdata`. A halfword at offset 2 covers bits 15:0. Lanes that were not accessed read as zero.
- R8: A halfword at an odd offset, a word at an offset that is not a multiple of 4, or size code 3 gives `rsp_err` high with `rsp_rdata` zero one cycle later, and changes no register.
- R9: A write takes effect at the next clock edge. If it changes a channel's byte, that channel's armed state is cleared at that edge. Rewriting the same value keeps it.
- R10: Aligned accesses at offsets beyond the last channel read zero, write nothing and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data, big-endian lanes |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Misaligned or bad-size access |
| rsp_rdata | output | 32 | Read data |
| src_req | input | 64 | Source request slots |
| trig_pulse | input | NUM_CH | Periodic trigger pulse per channel |
| ch_req | output | NUM_CH | Request to each DMA channel |

## Verification
The assertions assume that `src_req` and `trig_pulse` change only between clock edges, and that at most one register access is presented per cycle. The bench drives every input on the falling edge and walks requests through a task that holds `req_valid` for exactly one cycle. The periodic-mode property assumes the source inputs are synchronous levels, not glitches inside a cycle.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  localparam int SRC_W  = 6;
  localparam int SRC_N  = 1 << SRC_W;
  localparam int CFG_W  = 8;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / CFG_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  // MSB-first: en is byte bit 7, trg bit 6, src bits 5:0
  typedef struct packed {
    logic             en;
    logic             trg;
    logic [SRC_W-1:0] src;
  } ch_cfg_t;

  function automatic logic access_ok(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: access_ok = 1'b1;
      SZ_HALF: access_ok = ~off[0];
      SZ_WORD: access_ok = (off == 2'b00);
      default: access_ok = 1'b0;
    endcase
  endfunction

  // bit k set when lane k (byte offset k inside the word) is touched
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << off;
      SZ_HALF: lane_mask = off[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: lane_mask = 4'b1111;
      default: lane_mask = 4'b0000;
    endcase
  endfunction

  // big-endian: lane 0 sits in the top byte
  function automatic int unsigned lane_lsb(input int unsigned lane);
    lane_lsb = WORD_W - CFG_W * (lane + 1);
  endfunction
endpackage

// File: rtl/dmr_regfile.sv
module dmr_regfile
  import dmr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [1:0]               req_size,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [WORD_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic                     rsp_err,
  output logic [WORD_W-1:0]        rsp_rdata,
  output logic [NUM_CH*CFG_W-1:0]  cfg_flat,
  output logic [NUM_CH-1:0]        cfg_chg,
  output logic                     acc_err
);
  localparam int WIDX_W = ADDR_W - 2;

  ch_cfg_t            cfg_q [NUM_CH];
  logic               acc_ok;
  logic [LANES-1:0]   mask;
  logic [WIDX_W-1:0]  widx;
  logic [NUM_CH-1:0]  wr_en;
  logic [WORD_W-1:0]  rd_word;

  assign acc_ok  = access_ok(req_size, req_addr[1:0]);
  assign mask    = acc_ok ? lane_mask(req_size, req_addr[1:0]) : '0;
  assign widx    = req_addr[ADDR_W-1:2];
  assign acc_err = req_valid & ~acc_ok;

  always_comb begin
    rd_word = '0;
    wr_en   = '0;
    cfg_chg = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (widx == WIDX_W'(i / LANES) && mask[i % LANES]) begin
        rd_word[lane_lsb(i % LANES) +: CFG_W] = cfg_q[i];
        wr_en[i]   = req_valid & req_write;
        cfg_chg[i] = wr_en[i] &
                     (req_wdata[lane_lsb(i % LANES) +: CFG_W] != cfg_q[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) cfg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (wr_en[i]) cfg_q[i] <= ch_cfg_t'(req_wdata[lane_lsb(i % LANES) +: CFG_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= acc_err;
      rsp_rdata <= (req_valid && !req_write && acc_ok) ? rd_word : '0;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
      assign cfg_flat[g*CFG_W +: CFG_W] = cfg_q[g];
    end
  endgenerate
endmodule

// File: rtl/dmr_chan.sv
module dmr_chan
  import dmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ch_cfg_t          cfg,
  input  logic             cfg_chg,
  input  logic [SRC_N-1:0] src_req,
  input  logic             trig,
  output logic             req_o,
  output logic             armed_o,
  output logic             sel_o
);
  logic armed_q, src_q, periodic, arm_evt, done_evt;

  assign sel_o    = (cfg.src != '0) & src_req[cfg.src];
  assign periodic = cfg.en & cfg.trg;
  assign arm_evt  = periodic & trig;
  assign done_evt = armed_q & src_q & ~sel_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      src_q   <= 1'b0;
    end else begin
      src_q <= sel_o;
      if (cfg_chg || !periodic) armed_q <= 1'b0;
      else if (arm_evt)         armed_q <= 1'b1;
      else if (done_evt)        armed_q <= 1'b0;
    end
  end

  assign armed_o = armed_q;
  assign req_o   = cfg.en & sel_o & (~cfg.trg | armed_q);
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  input  logic [63:0]       src_req,
  input  logic [NUM_CH-1:0] trig_pulse,
  output logic [NUM_CH-1:0] ch_req
);
  logic [NUM_CH*CFG_W-1:0] cfg_flat;
  logic [NUM_CH-1:0]       cfg_chg;
  logic [NUM_CH-1:0]       armed_vec;
  logic [NUM_CH-1:0]       sel_vec;
  logic                    acc_err;

  dmr_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_flat(cfg_flat), .cfg_chg(cfg_chg), .acc_err(acc_err)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      dmr_chan u_ch (
        .clk(clk), .rst_n(rst_n),
        .cfg(ch_cfg_t'(cfg_flat[g*CFG_W +: CFG_W])),
        .cfg_chg(cfg_chg[g]),
        .src_req(src_req),
        .trig(trig_pulse[g]),
        .req_o(ch_req[g]),
        .armed_o(armed_vec[g]),
        .sel_o(sel_vec[g])
      );
    end
  endgenerate
endmodule

// File: rtl/dmr_checker.sv
module dmr_checker #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic [63:0]       src_req,
  input logic [NUM_CH-1:0] ch_req,
  input logic [NUM_CH*8-1:0] cfg_flat,
  input logic [NUM_CH-1:0] armed_vec
);
  logic bad_acc;
  assign bad_acc = (req_size == 2'd3) ||
                   (req_size == 2'd1 && req_addr[0]) ||
                   (req_size == 2'd2 && req_addr[1:0] != 2'b00);

  AST_BAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && bad_acc |=> rsp_err && rsp_rdata == 32'd0); // R8
  AST_BAD_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && bad_acc |=> $stable(cfg_flat)); // R8
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7
  AST_ERR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R7

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ast
      logic       en, trg;
      logic [5:0] src;
      assign en  = cfg_flat[g*8+7];
      assign trg = cfg_flat[g*8+6];
      assign src = cfg_flat[g*8 +: 6];

      AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !ch_req[g]); // R3
      AST_SLOT0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        src == 6'd0 |-> !ch_req[g]); // R6
      AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        en && !trg && src != 6'd0 |-> ch_req[g] == src_req[src]); // R4
      AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        en && trg && ch_req[g] |-> armed_vec[g]); // R5
    end
  endgenerate
endmodule

bind dma_req_router dmr_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .src_req(src_req), .ch_req(ch_req),
  .cfg_flat(cfg_flat), .armed_vec(armed_vec)
);

// File: tb/sim_dma_req_router.sv
module sim_dma_req_router;
  localparam int NCH = 16;
  localparam int AW  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]     req_size = 2'd0;
  logic [AW-1:0]  req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic           rsp_valid, rsp_err;
  logic [31:0]    rsp_rdata;
  logic [63:0]    src_req = '0;
  logic [NCH-1:0] trig_pulse = '0;
  logic [NCH-1:0] ch_req;

  int total = 0, bad = 0;
  logic done = 1'b0;
  logic        r_err, r_val;
  logic [31:0] r_data;

  always #4 clk = ~clk;

  dma_req_router #(.NUM_CH(NCH), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .src_req(src_req), .trig_pulse(trig_pulse), .ch_req(ch_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                     input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    r_val = rsp_valid; r_err = rsp_err; r_data = rsp_rdata;
  endtask

  task automatic wbyte(input int ch, input logic [7:0] v);
    bus(1'b1, 2'd0, AW'(ch), {v, v, v, v});
  endtask

  // {ch[3:0], cfg[7:0], src bit[5:0], expected}
  localparam logic [18:0] TBL [8] = '{
    {4'd0,  8'h81, 6'd1,  1'b1},   // R1 R4: enable, slot 1
    {4'd0,  8'h81, 6'd2,  1'b0},   // R4: other slot active
    {4'd1,  8'h45, 6'd5,  1'b0},   // R3: disabled with trigger bit
    {4'd4,  8'h80, 6'd0,  1'b0},   // R6: slot 0
    {4'd15, 8'hBF, 6'd63, 1'b1},   // R4: last channel, last slot
    {4'd7,  8'h8A, 6'd10, 1'b1},   // R4
    {4'd7,  8'h8A, 6'd11, 1'b0},   // R4
    {4'd9,  8'hC3, 6'd3,  1'b0}    // R5: periodic, unarmed
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state
    src_req = '1; trig_pulse = '1;
    @(negedge clk); @(negedge clk);
    chk("R2 ch_req", 32'(ch_req), 32'd0);
    src_req = '0; trig_pulse = '0;
    bus(1'b0, 2'd2, 8'h00, 32'd0);
    chk("R2 read", r_data, 32'd0);
    chk("R2 valid", 32'(r_val), 32'd1);

    foreach (TBL[k]) begin
      logic [18:0] e;
      e = TBL[k];
      wbyte(int'(e[18:15]), e[14:7]);
      src_req = 64'd1 << e[6:1];
      @(negedge clk);
      chk("R1/R3/R4/R5/R6 table", 32'(ch_req[e[18:15]]), 32'(e[0]));
      src_req = '0;
    end

    // R5: periodic mode on channel 2, slot 5
    wbyte(2, 8'hC5);
    src_req[5] = 1'b1;
    @(negedge clk);
    chk("R5 unarmed", 32'(ch_req[2]), 32'd0);
    trig_pulse[2] = 1'b1;
    @(negedge clk);
    trig_pulse[2] = 1'b0;
    chk("R5 armed", 32'(ch_req[2]), 32'd1);
    src_req[5] = 1'b0;
    @(negedge clk);
    chk("R5 source low", 32'(ch_req[2]), 32'd0);
    src_req[5] = 1'b1;
    @(negedge clk);
    chk("R5 disarmed after fall", 32'(ch_req[2]), 32'd0);
    src_req[5] = 1'b0;
    trig_pulse[2] = 1'b1;
    @(negedge clk);
    trig_pulse[2] = 1'b0;
    repeat (2) @(negedge clk);
    src_req[5] = 1'b1;
    @(negedge clk);
    chk("R5 early trigger kept", 32'(ch_req[2]), 32'd1);
    // R9: same value keeps arm, changed value clears it
    wbyte(2, 8'hC5);
    chk("R9 same value", 32'(ch_req[2]), 32'd1);
    src_req[6] = 1'b1;
    wbyte(2, 8'hC6);
    chk("R9 changed clears", 32'(ch_req[2]), 32'd0);
    src_req = '0;

    // R7: lanes and widths
    bus(1'b1, 2'd2, 8'h00, 32'h81828384);
    chk("R7 wr no err", 32'(r_err), 32'd0);
    bus(1'b0, 2'd2, 8'h00, 32'd0);
    chk("R7 word", r_data, 32'h81828384);
    bus(1'b0, 2'd0, 8'h03, 32'd0);
    chk("R7 byte lane3", r_data, 32'h00000084);
    bus(1'b0, 2'd1, 8'h02, 32'd0);
    chk("R7 half", r_data, 32'h00008384);
    bus(1'b1, 2'd1, 8'h00, 32'h9192AAAA);
    bus(1'b0, 2'd2, 8'h00, 32'd0);
    chk("R7 half write", r_data, 32'h91928384);
    src_req[4] = 1'b1;
    @(negedge clk);
    chk("R1 ch3 byte 0x84", 32'(ch_req[3]), 32'd1);
    src_req = '0;

    // R8: misaligned and bad size
    bus(1'b1, 2'd2, 8'h01, 32'hFFFFFFFF);
    chk("R8 word@1 err", 32'(r_err), 32'd1);
    bus(1'b0, 2'd1, 8'h01, 32'd0);
    chk("R8 half@1 err", 32'(r_err), 32'd1);
    chk("R8 rdata zero", r_data, 32'd0);
    bus(1'b0, 2'd3, 8'h00, 32'd0);
    chk("R8 size3 err", 32'(r_err), 32'd1);
    bus(1'b0, 2'd2, 8'h00, 32'd0);
    chk("R8 unchanged", r_data, 32'h91928384);
    chk("R8 aligned no err", 32'(r_err), 32'd0);

    // R10: beyond last channel
    bus(1'b1, 2'd2, 8'h40, 32'hFFFFFFFF);
    chk("R10 no err", 32'(r_err), 32'd0);
    bus(1'b0, 2'd2, 8'h40, 32'd0);
    chk("R10 read zero", r_data, 32'd0);
    bus(1'b0, 2'd2, 8'h0C, 32'd0);
    chk("R10 last word intact", r_data, 32'h000000BF);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule